// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block connects an internal request port to an external asynchronous byte-wide static RAM. It accepts read and write requests with a valid/ready handshake. It drives the RAM's active-low chip select, output enable, write enable and sleep pins, the address pins and a shared tri-state data bus. Read data comes back on a response port with a one-cycle valid strobe. Every analog timing gap of the RAM is expressed as a whole number of clock cycles through parameters. Each of these parameters is at least 1.

Reads are started by a change of address. Chip select and output enable stay low across a run of reads, so each new read only moves the address. Writes are framed by write enable while chip select is held low. Each write has an address setup phase, a pulse of fixed width, an address and data hold phase and a recovery gap. After a programmable number of idle cycles, the controller pulls the sleep pin low. A later request first releases sleep and waits a wake delay before the access begins. The controller leaves reset asleep.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, ram_sl_n is 0, ram_cs_n, ram_oe_n and ram_we_n are 1, req_ready is 0 and rsp_valid is 0.
- R2: ram_oe_n is low only while ram_cs_n is low, ram_we_n is high and ram_sl_n is high.
- R3: A read accepted on clock edge A raises rsp_valid for exactly one cycle on edge A+ACCESS_CYC. rsp_data then holds the byte stored at the address, which has been held stable on ram_addr for ACCESS_CYC cycles.
- R4: During a run of reads with no write or sleep between them, ram_cs_n and ram_oe_n stay low and ram_sl_n stays high, and only ram_addr changes.
- R5: Each write holds ram_we_n low for exactly PULSE_CYC cycles. During the pulse, ram_cs_n is low, ram_oe_n and ram_sl_n are high, and the request's write byte is driven on ram_dq.
- R6: The write address is on ram_addr for at least SETUP_CYC cycles before ram_we_n falls. It does not change while ram_we_n is low. It is held for HOLD_CYC cycles after ram_we_n rises.
- R7: Between the rise of one write pulse and the fall of the next, ram_we_n stays high for at least HOLD_CYC+RECOVER_CYC cycles.
- R8: The controller drives ram_dq only while ram_oe_n is high. It has released the bus for at least one cycle before ram_oe_n falls, so a read that follows a write sees no bus contention.
- R9: When IDLE_CYC is non-zero, ram_sl_n falls exactly IDLE_CYC cycles after a read response if no request arrives in between. While asleep, ram_cs_n, ram_oe_n and ram_we_n are high. IDLE_CYC = 0 disables sleep entry.
- R10: A request that arrives while asleep raises ram_sl_n. req_ready rises exactly WAKE_CYC cycles later. req_ready is 0 whenever ram_sl_n is 0.
- R11: One request is taken per cycle in which req_valid and req_ready are both 1. req_ready is 0 on the following cycle, and read responses come back in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_data | output | DATA_W | Read byte |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_sl_n | output | 1 | RAM sleep control, low = sleeping |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_dq | inout | DATA_W | RAM bidirectional data bus |

## Verification
The bench's RAM model returns inverted data until the address has been stable for the access time, so a response that is captured early shows up as a data error and not as a silent pass. Writes are tried with all-zero, all-one and alternating bytes. The test includes back-to-back writes to one address, which separates the recovery gap from the setup phase. Reads run as chained bursts, include a repeated read of an unchanged address, and include a read that directly follows a write, which exercises bus turnaround. A stretch of idle cycles followed by a request checks the exact sleep entry time and the exact wake delay.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_SLEEP,
      ST_WAKE,
      ST_IDLE,
      ST_RD,
      ST_WSU,
      ST_WP,
      ST_WHD,
      ST_WREC
   } sc_state_e;

   function automatic int unsigned sc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_idle.sv
module sram_ctl_idle #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic count_en,
   output logic expire
);
   localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   logic [W-1:0] cnt;

   if (LIMIT < 1) begin : g_bad_limit
      $error("sram_ctl_idle: LIMIT must be at least 1");
   end

   assign expire = count_en && (cnt == W'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!count_en)
         cnt <= '0;
      else if (!expire)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 8,
   parameter int ACCESS_CYC  = 4,
   parameter int PULSE_CYC   = 3,
   parameter int RECOVER_CYC = 2,
   parameter int SETUP_CYC   = 1,
   parameter int HOLD_CYC    = 1,
   parameter int IDLE_CYC    = 64,
   parameter int WAKE_CYC    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              ram_cs_n,
   output logic              ram_oe_n,
   output logic              ram_we_n,
   output logic              ram_sl_n,
   output logic [ADDR_W-1:0] ram_addr,
   inout  wire  [DATA_W-1:0] ram_dq
);
   localparam int unsigned MAX_A = sc_max(ACCESS_CYC, PULSE_CYC);
   localparam int unsigned MAX_B = sc_max(RECOVER_CYC, sc_max(SETUP_CYC, HOLD_CYC));
   localparam int unsigned MAX_C = sc_max(MAX_A, sc_max(MAX_B, WAKE_CYC));
   localparam int TW = (MAX_C < 2) ? 1 : $clog2(MAX_C);

   if (ACCESS_CYC < 1 || PULSE_CYC < 1 || RECOVER_CYC < 1 ||
       SETUP_CYC < 1 || HOLD_CYC < 1 || WAKE_CYC < 1) begin : g_bad_cycles
      $error("sram_ctl: every cycle count parameter must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_ctl: widths must be at least 1");
   end
   if (IDLE_CYC < 0) begin : g_bad_idle
      $error("sram_ctl: IDLE_CYC must not be negative");
   end

   sc_state_e         st, st_n;
   logic              t_ld, t_done;
   logic [TW-1:0]     t_val;
   logic              idle_cnt_en, idle_exp;
   logic              accept;
   logic              dq_drv;
   logic [DATA_W-1:0] wd_q;

   sram_ctl_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_ld),
      .load_val (t_val),
      .done     (t_done)
   );

   assign idle_cnt_en = (st == ST_IDLE) && !req_valid;

   if (IDLE_CYC > 0) begin : g_idle
      sram_ctl_idle #(.LIMIT(IDLE_CYC)) u_idle (
         .clk      (clk),
         .rst_n    (rst_n),
         .count_en (idle_cnt_en),
         .expire   (idle_exp)
      );
   end else begin : g_no_idle
      assign idle_exp = 1'b0;
   end

   assign req_ready = (st == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign ram_dq    = dq_drv ? wd_q : 'z;

   // next state and phase timer loading
   always_comb begin
      st_n  = st;
      t_ld  = 1'b0;
      t_val = '0;
      unique case (st)
         ST_SLEEP: if (req_valid) begin
            st_n = ST_WAKE;  t_ld = 1'b1;  t_val = TW'(WAKE_CYC - 1);
         end
         ST_WAKE:  if (t_done) st_n = ST_IDLE;
         ST_IDLE: begin
            if (req_valid) begin
               t_ld = 1'b1;
               if (req_we) begin
                  st_n = ST_WSU;  t_val = TW'(SETUP_CYC - 1);
               end else begin
                  st_n = ST_RD;   t_val = TW'(ACCESS_CYC - 1);
               end
            end else if (idle_exp) begin
               st_n = ST_SLEEP;
            end
         end
         ST_RD:    if (t_done) st_n = ST_IDLE;
         ST_WSU:   if (t_done) begin
            st_n = ST_WP;    t_ld = 1'b1;  t_val = TW'(PULSE_CYC - 1);
         end
         ST_WP:    if (t_done) begin
            st_n = ST_WHD;   t_ld = 1'b1;  t_val = TW'(HOLD_CYC - 1);
         end
         ST_WHD:   if (t_done) begin
            st_n = ST_WREC;  t_ld = 1'b1;  t_val = TW'(RECOVER_CYC - 1);
         end
         ST_WREC:  if (t_done) st_n = ST_IDLE;
         default:  st_n = ST_SLEEP;
      endcase
   end

   // registered pin and response updates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_SLEEP;
         ram_sl_n  <= 1'b0;
         ram_cs_n  <= 1'b1;
         ram_oe_n  <= 1'b1;
         ram_we_n  <= 1'b1;
         ram_addr  <= '0;
         dq_drv    <= 1'b0;
         wd_q      <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         st        <= st_n;
         rsp_valid <= 1'b0;
         unique case (st)
            ST_SLEEP: if (req_valid) ram_sl_n <= 1'b1;
            ST_IDLE: begin
               if (accept) begin
                  ram_addr <= req_addr;
                  ram_cs_n <= 1'b0;
                  ram_oe_n <= req_we;
                  if (req_we) wd_q <= req_wdata;
               end else if (idle_exp) begin
                  ram_sl_n <= 1'b0;
                  ram_cs_n <= 1'b1;
                  ram_oe_n <= 1'b1;
               end
            end
            ST_RD: if (t_done) begin
               rsp_valid <= 1'b1;
               rsp_data  <= ram_dq;
            end
            ST_WSU: if (t_done) begin
               ram_we_n <= 1'b0;
               dq_drv   <= 1'b1;
            end
            ST_WP:  if (t_done) ram_we_n <= 1'b1;
            ST_WHD: if (t_done) dq_drv <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              ram_cs_n,
   input logic              ram_oe_n,
   input logic              ram_we_n,
   input logic              ram_sl_n,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              drive_en
);
   a_r2_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_oe_n |-> (!ram_cs_n && ram_we_n && ram_sl_n));

   a_r5_write_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_cs_n && ram_sl_n && ram_oe_n && drive_en));

   a_r6_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> $stable(ram_addr));

   a_r6_addr_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_addr));

   a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_we_n) |-> $stable(ram_addr));

   a_r8_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_oe_n) |-> !$past(drive_en));

   a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> ram_oe_n);

   a_r9_sleep_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_sl_n |-> (ram_cs_n && ram_we_n && ram_oe_n && !req_ready));

   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r11_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .ram_cs_n  (ram_cs_n),
   .ram_oe_n  (ram_oe_n),
   .ram_we_n  (ram_we_n),
   .ram_sl_n  (ram_sl_n),
   .ram_addr  (ram_addr),
   .drive_en  (dq_drv)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;
   localparam int AW = 8, DW = 8;
   localparam int ACC = 3, WP = 2, REC = 2, SU = 1, HD = 1, IDLE = 20, WAKE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          cs_n, oe_n, we_n, sl_n;
   logic [AW-1:0] ram_addr;
   wire  [DW-1:0] ram_dq;

   sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .PULSE_CYC(WP),
              .RECOVER_CYC(REC), .SETUP_CYC(SU), .HOLD_CYC(HD),
              .IDLE_CYC(IDLE), .WAKE_CYC(WAKE)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ram_cs_n(cs_n),
      .ram_oe_n(oe_n), .ram_we_n(we_n), .ram_sl_n(sl_n),
      .ram_addr(ram_addr), .ram_dq(ram_dq));

   int total = 0, bad = 0, cyc = 0;
   bit done_flag = 1'b0;
   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // behavioural RAM: inverted data until the address has settled
   logic [DW-1:0] mem [256];
   logic [DW-1:0] exp_mem [256];
   int            st = 0;
   logic [AW-1:0] last_a = '0;
   logic          ram_drv;
   logic [DW-1:0] ram_rd;
   assign ram_drv = !cs_n && !oe_n && we_n && sl_n;
   assign ram_rd  = (st >= ACC - 1) ? mem[ram_addr] : ~mem[ram_addr];
   assign ram_dq  = ram_drv ? ram_rd : 'z;

   logic [DW-1:0] q_data[$];
   int            q_cyc[$];
   logic [DW-1:0] last_wd = '0;
   logic [AW-1:0] pulse_a = '0, prev_a = '0;
   bit            prev_we = 1'b1, prev_sl = 1'b0, prev_oe = 1'b1;
   int            lowcnt = 0, gap = 0, astab = 0, hold_left = 0;
   bit            sl_act = 1'b0, wk_act = 1'b0, chain_on = 1'b0;
   int            sl_meas = 0, wk = 0;

   always @(negedge clk) if (rst_n && !done_flag) begin
      // RAM model state
      if (ram_addr != last_a) st = 0; else if (st < 1000) st++;
      last_a = ram_addr;
      if (!we_n && !cs_n && sl_n) mem[ram_addr] = ram_dq;

      // request acceptance and expected responses
      if (req_valid && req_ready) begin
         if (req_we) begin
            exp_mem[req_addr] = req_wdata;
            last_wd = req_wdata;
         end else begin
            q_data.push_back(exp_mem[req_addr]);
            q_cyc.push_back(cyc + 1);
         end
      end
      if (rsp_valid) begin
         chk(q_data.size() > 0, "R11 response without request", q_data.size(), 1);
         if (q_data.size() > 0) begin
            chk(rsp_data == q_data[0], "R3 read data", rsp_data, q_data[0]);
            chk(cyc == q_cyc[0] + ACC, "R3 read latency", cyc - q_cyc[0], ACC);
            void'(q_data.pop_front());
            void'(q_cyc.pop_front());
         end
      end

      // read pin rules
      if (!oe_n) chk(!cs_n && we_n && sl_n, "R2 read pins", {cs_n, we_n, sl_n}, 3'b011);
      if (chain_on) chk(!cs_n && !oe_n && sl_n, "R4 chained read pins", {cs_n, oe_n, sl_n}, 3'b001);
      if (!oe_n && prev_oe && gap > 0) chk(gap >= HD + 1, "R8 bus released before read", gap, HD + 1);

      // write pulse shape
      if (ram_addr != prev_a) astab = 0; else astab++;
      if (!we_n) begin
         if (prev_we) begin
            chk(astab >= SU, "R6 address setup", astab, SU);
            if (gap > 0) chk(gap >= HD + REC, "R7 recovery gap", gap, HD + REC);
            pulse_a = ram_addr;
         end else begin
            chk(ram_addr == pulse_a, "R6 address stable in pulse", ram_addr, pulse_a);
         end
         chk(ram_dq == last_wd, "R5 write data on bus", ram_dq, last_wd);
         chk(!cs_n && oe_n && sl_n, "R5 write pins", {cs_n, oe_n, sl_n}, 3'b011);
         lowcnt++;
         gap = 0;
      end else begin
         if (!prev_we) begin
            chk(lowcnt == WP, "R5 pulse width", lowcnt, WP);
            lowcnt = 0;
            gap = 1;
            hold_left = HD;
         end else if (gap > 0) gap++;
         if (hold_left > 0) begin
            chk(ram_addr == pulse_a, "R6 address hold", ram_addr, pulse_a);
            hold_left--;
         end
      end

      // sleep entry timing
      if (rsp_valid) begin
         sl_act = !req_valid;
         sl_meas = 0;
      end else if (sl_act) begin
         if (req_valid) sl_act = 1'b0;
         else begin
            sl_meas++;
            if (!sl_n) begin
               chk(sl_meas == IDLE, "R9 sleep entry time", sl_meas, IDLE);
               chk(cs_n && oe_n && we_n, "R9 pins while asleep", {cs_n, oe_n, we_n}, 3'b111);
               sl_act = 1'b0;
            end
         end
      end

      // wake timing
      if (!sl_n) chk(!req_ready, "R10 not ready while asleep", req_ready, 0);
      if (sl_n && !prev_sl) begin
         wk_act = 1'b1;
         wk = 0;
      end else if (wk_act) begin
         wk++;
         if (req_ready) begin
            chk(wk == WAKE, "R10 wake delay", wk, WAKE);
            wk_act = 1'b0;
         end
      end

      prev_we = we_n;
      prev_sl = sl_n;
      prev_oe = oe_n;
      prev_a  = ram_addr;
   end

   task automatic do_req(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge clk); #2;
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) begin @(posedge clk); #2; end
      @(posedge clk); #2;
      req_valid = 1'b0;
      chk(!req_ready, "R11 busy after accept", req_ready, 0);
   endtask

   task automatic drain();
      while (q_data.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = DW'(i * 7 + 3);
         exp_mem[i] = mem[i];
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!sl_n && cs_n && oe_n && we_n, "R1 pins in reset", {sl_n, cs_n, oe_n, we_n}, 4'b0111);
      chk(!req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!sl_n && cs_n && oe_n && we_n, "R1 pins after reset", {sl_n, cs_n, oe_n, we_n}, 4'b0111);
      chk(!req_ready && !rsp_valid, "R1 handshake after reset", {req_ready, rsp_valid}, 0);

      // writes of distinct patterns (first one wakes the RAM)
      do_req(1'b1, 8'h10, 8'h00);
      do_req(1'b1, 8'h11, 8'hFF);
      do_req(1'b1, 8'h12, 8'hA5);
      do_req(1'b1, 8'h13, 8'h5A);
      // back-to-back writes to one address
      do_req(1'b1, 8'h20, 8'h3C);
      do_req(1'b1, 8'h20, 8'hC3);

      // read right after write, then a chained burst
      do_req(1'b0, 8'h20, 8'h00);
      drain();
      chain_on = 1'b1;
      do_req(1'b0, 8'h10, 8'h00);
      do_req(1'b0, 8'h11, 8'h00);
      do_req(1'b0, 8'h12, 8'h00);
      do_req(1'b0, 8'h12, 8'h00);
      do_req(1'b0, 8'h13, 8'h00);
      do_req(1'b0, 8'h77, 8'h00);
      drain();
      chain_on = 1'b0;

      // let it fall asleep, then wake with a write and read back
      repeat (IDLE + 5) @(posedge clk);
      @(negedge clk);
      chk(!sl_n, "R9 asleep after idle", sl_n, 0);
      do_req(1'b1, 8'h40, 8'h96);
      do_req(1'b0, 8'h40, 8'h00);
      do_req(1'b0, 8'hFF, 8'h00);
      drain();
      repeat (IDLE + 5) @(posedge clk);
      do_req(1'b0, 8'h11, 8'h00);
      drain();
      chk(q_data.size() == 0, "R11 all responses returned", q_data.size(), 0);
      report();
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", cyc, 0);
      report();
   end
endmodule